// File: doc/BRIEF.md
# Single-Accumulator Instruction Processor

This block is a minimal stored-program core built around one accumulator register. It fetches 16-bit instruction words from a single word-addressed synchronous memory, decodes a 4-bit operation and a 12-bit direct operand address, and executes loads, additions, subtractions and stores against the accumulator. Program flow is changed with an unconditional jump and a jump taken only when the last accumulator-writing result was zero.

Every instruction takes three clock cycles: fetch, decode with operand read, and execute. Memory reads return data one cycle after the address is presented, and a store is a one-cycle write strobe. After reset the core spends one cycle loading its program counter from the start-address input and then runs until it meets a halt opcode or any opcode it does not recognise. From then on it holds still and raises its halted output.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, halted_o and mem_we_o are low. The first instruction fetch uses the address on start_addr_i.
- R2: An instruction word carries its operation code in bits 15:12 and its operand address in bits 11:0.
- R3: Opcode 4'h2 (load) copies the addressed memory word into the accumulator and sets the zero flag when that word is zero, and clears it otherwise.
- R4: Opcode 4'h1 (add) replaces the accumulator with the accumulator plus the addressed word, modulo 2^16. It updates the zero flag from the sum.
- R5: Opcode 4'h4 (subtract) replaces the accumulator with the accumulator minus the addressed word, modulo 2^16. It updates the zero flag from the difference.
- R6: Opcode 4'h3 (store) writes the accumulator to the operand address with mem_we_o high for exactly one cycle. The accumulator is unchanged afterwards.
- R7: Opcode 4'h5 (jump-if-zero) loads the program counter with its operand address when the zero flag is set. Otherwise the next instruction is the following word.
- R8: Opcode 4'h6 (jump) always loads the program counter with its operand address, forward or backward.
- R9: Store and both jumps leave the zero flag unchanged.
- R10: Opcode 4'h0 and any opcode above 4'h6 halt the core. halted_o then stays high, no further write happens, and mem_addr_o holds still.
- R11: Each instruction takes three cycles and, without a taken jump, the program counter advances by one. A program of N instructions ending in a halt raises halted_o 1+3*N clock edges after reset is released.
- R12: The program load 0x201, add 0x202, add 0x203, store 0x204, halt leaves 9 in word 0x204 when words 0x201 to 0x203 hold 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_addr_i | input | 12 | Address of the first instruction, sampled once after reset |
| mem_addr_o | output | 12 | Memory word address |
| mem_wdata_o | output | 16 | Write data (accumulator) |
| mem_we_o | output | 1 | Write enable, one cycle per store |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the address |
| halted_o | output | 1 | Core has stopped |

## Verification
The assertions assume that the memory returns, one cycle later, the word at the address presented. They also assume that start_addr_i is steady from reset release until the first fetch. The bench models a memory with exactly that one-cycle latency and sets the start address before reset is released and not again during a run. The directed programs drive every opcode, both outcomes of the conditional jump, a backward loop, additive wraparound to zero and an unrecognised opcode. Results are checked through final memory contents and cycle counts to halt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam logic [3:0] OPC_HALT  = 4'h0;
  localparam logic [3:0] OPC_ADD   = 4'h1;
  localparam logic [3:0] OPC_LOAD  = 4'h2;
  localparam logic [3:0] OPC_STORE = 4'h3;
  localparam logic [3:0] OPC_SUB   = 4'h4;
  localparam logic [3:0] OPC_JZ    = 4'h5;
  localparam logic [3:0] OPC_JMP   = 4'h6;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_HALT
  } cpu_state_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } alu_op_e;

  typedef struct packed {
    logic    acc_we;
    alu_op_e alu_op;
    logic    mem_we;
    logic    jmp;
    logic    jz;
    logic    halt;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
#(
  parameter int unsigned OPC_W = 4
) (
  input  logic [OPC_W-1:0] opc_i,
  output ctrl_t            ctrl_o
);

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_PASS;
    unique case (opc_i)
      OPC_LOAD: ctrl_o.acc_we = 1'b1;
      OPC_ADD: begin
        ctrl_o.acc_we = 1'b1;
        ctrl_o.alu_op = ALU_ADD;
      end
      OPC_SUB: begin
        ctrl_o.acc_we = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OPC_STORE: ctrl_o.mem_we = 1'b1;
      OPC_JZ:    ctrl_o.jz     = 1'b1;
      OPC_JMP:   ctrl_o.jmp    = 1'b1;
      default:   ctrl_o.halt   = 1'b1; // halt and every unknown code
    endcase
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  output logic [DW-1:0] res_o,
  output logic          zero_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = acc_i + opnd_i;
      ALU_SUB: res_o = acc_i - opnd_i;
      default: res_o = opnd_i;
    endcase
  end

  assign zero_o = (res_o == '0);

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 12,
  localparam int unsigned OPC_W = DW - AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    start_addr_i,
  input  logic [DW-1:0]    instr_i,
  input  logic             halt_i,
  input  logic             take_jump_i,
  output cpu_state_e       state_o,
  output logic [AW-1:0]    pc_o,
  output logic [OPC_W-1:0] ir_opc_o,
  output logic [AW-1:0]    ir_addr_o
);

  cpu_state_e state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] ir_q;

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    unique case (state_q)
      ST_BOOT: begin
        pc_d    = start_addr_i;
        state_d = ST_FETCH;
      end
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC: begin
        if (halt_i) begin
          state_d = ST_HALT;
        end else begin
          state_d = ST_FETCH;
          pc_d    = take_jump_i ? ir_q[AW-1:0] : pc_q + AW'(1);
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
      pc_q    <= '0;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      if (state_q == ST_DECODE) ir_q <= instr_i;
    end
  end

  assign state_o   = state_q;
  assign pc_o      = pc_q;
  assign ir_opc_o  = ir_q[DW-1:AW];
  assign ir_addr_o = ir_q[AW-1:0];

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] start_addr_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          halted_o
);

  localparam int unsigned OPC_W = DW - AW;

  cpu_state_e       state;
  logic [AW-1:0]    pc;
  logic [OPC_W-1:0] ir_opc;
  logic [AW-1:0]    ir_addr;
  ctrl_t            ctrl;
  logic [DW-1:0]    acc_q, alu_res;
  logic             zero_q, alu_zero;
  logic             in_exec, take_jump;

  assign in_exec   = (state == ST_EXEC);
  assign take_jump = ctrl.jmp | (ctrl.jz & zero_q);

  acc_cpu_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_addr_i(start_addr_i),
    .instr_i     (mem_rdata_i),
    .halt_i      (ctrl.halt),
    .take_jump_i (take_jump),
    .state_o     (state),
    .pc_o        (pc),
    .ir_opc_o    (ir_opc),
    .ir_addr_o   (ir_addr)
  );

  acc_cpu_decode #(.OPC_W(OPC_W)) u_dec (
    .opc_i (ir_opc),
    .ctrl_o(ctrl)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op_i  (ctrl.alu_op),
    .acc_i (acc_q),
    .opnd_i(mem_rdata_i),
    .res_o (alu_res),
    .zero_o(alu_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      zero_q <= 1'b0;
    end else if (in_exec && ctrl.acc_we) begin
      acc_q  <= alu_res;
      zero_q <= alu_zero;
    end
  end

  // decode cycle issues the operand read straight from the fetched word
  always_comb begin
    unique case (state)
      ST_FETCH:  mem_addr_o = pc;
      ST_DECODE: mem_addr_o = mem_rdata_i[AW-1:0];
      ST_EXEC:   mem_addr_o = ir_addr;
      default:   mem_addr_o = pc;
    endcase
  end

  assign mem_wdata_o = acc_q;
  assign mem_we_o    = in_exec & ctrl.mem_we;
  assign halted_o    = (state == ST_HALT);

endmodule

// File: rtl/acc_cpu_sva.sv
module acc_cpu_sva #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] start_addr_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic          halted_o
);

  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)   cyc_q <= cyc_q + 2'd1;
  end

  assert_first_fetch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd1) |-> (mem_addr_o == start_addr_i && !halted_o));

  assert_store_target_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(mem_rdata_i[DW-1:AW]) == 4'h3 &&
                  mem_addr_o == $past(mem_rdata_i[AW-1:0])));

  assert_store_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  assert_store_keeps_acc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> $stable(mem_wdata_o));

  assert_halt_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  assert_halt_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o);

  assert_halt_addr_still_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && $past(halted_o)) |-> $stable(mem_addr_o));

endmodule

bind acc_cpu acc_cpu_sva #(.DW(DW), .AW(AW)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_addr_i(start_addr_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_we_o    (mem_we_o),
  .mem_rdata_i (mem_rdata_i),
  .halted_o    (halted_o)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] start_addr_i = '0;
  logic [11:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_we_o;
  logic [15:0] mem_rdata_i;
  logic        halted_o;

  logic [15:0] mem [0:1023];
  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  acc_cpu u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_addr_i(start_addr_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_rdata_i (mem_rdata_i),
    .halted_o    (halted_o)
  );

  always @(posedge clk_i) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o[9:0]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    @(negedge clk_i);
    ld_en = 1'b1; ld_addr = 10'(a); ld_data = d;
    @(negedge clk_i);
    ld_en = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) poke(i, 16'h0);
  endtask

  task automatic run(input logic [11:0] start, output int cyc);
    @(negedge clk_i);
    rst_ni = 1'b0;
    start_addr_i = start;
    repeat (2) @(negedge clk_i);
    check("R1 reset halted", {31'd0, halted_o}, 32'd0);
    check("R1 reset we", {31'd0, mem_we_o}, 32'd0);
    rst_ni = 1'b1;
    cyc = 0;
    while (!halted_o && cyc < 2000) begin
      @(posedge clk_i); #1;
      cyc++;
    end
  endtask

  task automatic t_sum();
    int cyc;
    poke(12'h101, 16'h2201); poke(12'h102, 16'h1202);
    poke(12'h103, 16'h1203); poke(12'h104, 16'h3204);
    poke(12'h105, 16'h0000);
    poke(12'h201, 16'd2); poke(12'h202, 16'd3);
    poke(12'h203, 16'd4); poke(12'h204, 16'd0);
    run(12'h101, cyc);
    check("R12 sum result", {16'd0, mem[10'h204]}, 32'd9);
    check("R3 load leaves source", {16'd0, mem[10'h201]}, 32'd2);
    check("R11 cycles sum", cyc, 32'd16);
    check("R1 start address honoured", {31'd0, halted_o}, 32'd1);
  endtask

  task automatic t_countdown();
    int cyc;
    clear_mem();
    poke(0, 16'h2100); poke(1, 16'h4101); poke(2, 16'h3100);
    poke(3, 16'h5006); poke(4, 16'h6001); poke(5, 16'h0000);
    poke(6, 16'h3102); poke(7, 16'h0000);
    poke(12'h100, 16'd3); poke(12'h101, 16'd1); poke(12'h102, 16'h5555);
    run(12'h000, cyc);
    check("R5 subtract reached zero", {16'd0, mem[10'h100]}, 32'd0);
    check("R7 taken jump exit store", {16'd0, mem[10'h102]}, 32'd0);
    check("R8 backward loop cycles", cyc, 32'd43);
  endtask

  task automatic t_flag_hold();
    int cyc;
    clear_mem();
    poke(0, 16'h2100); poke(1, 16'h3101); poke(2, 16'h6004);
    poke(3, 16'h3102); poke(4, 16'h5006); poke(5, 16'h3103);
    poke(6, 16'h2104); poke(7, 16'h5009); poke(8, 16'h3105);
    poke(9, 16'h0000);
    poke(12'h100, 16'h0000); poke(12'h101, 16'hAAAA); poke(12'h102, 16'hBBBB);
    poke(12'h103, 16'hCCCC); poke(12'h104, 16'h0007); poke(12'h105, 16'h0000);
    run(12'h000, cyc);
    check("R6 store of zero", {16'd0, mem[10'h101]}, 32'd0);
    check("R8 forward jump skips", {16'd0, mem[10'h102]}, 32'hBBBB);
    check("R9 flag kept across store and jump", {16'd0, mem[10'h103]}, 32'hCCCC);
    check("R7 not taken falls through", {16'd0, mem[10'h105]}, 32'd7);
    check("R11 cycles flag program", cyc, 32'd25);
  endtask

  task automatic t_wrap();
    int cyc;
    clear_mem();
    poke(0, 16'h2100); poke(1, 16'h1101); poke(2, 16'h5004);
    poke(3, 16'h3102); poke(4, 16'h3103); poke(5, 16'h0000);
    poke(12'h100, 16'hFFFF); poke(12'h101, 16'h0001);
    poke(12'h102, 16'h1234); poke(12'h103, 16'h5555);
    run(12'h000, cyc);
    check("R4 add wraps to zero", {16'd0, mem[10'h103]}, 32'd0);
    check("R4 add sets zero flag", {16'd0, mem[10'h102]}, 32'h1234);
    check("R11 cycles wrap", cyc, 32'd16);
  endtask

  task automatic t_illegal();
    int cyc;
    int writes;
    logic [11:0] a0;
    clear_mem();
    poke(0, 16'h2100); poke(1, 16'hF000); poke(2, 16'h3101); poke(3, 16'h0000);
    poke(12'h100, 16'd5); poke(12'h101, 16'h7777);
    run(12'h000, cyc);
    check("R10 unknown opcode halts", cyc, 32'd7);
    writes = 0;
    a0 = mem_addr_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (mem_we_o) writes++;
    end
    check("R10 no write while halted", writes, 32'd0);
    check("R10 halted stays high", {31'd0, halted_o}, 32'd1);
    check("R10 address held", {20'd0, mem_addr_o}, {20'd0, a0});
    check("R2 store after halt skipped", {16'd0, mem[10'h101]}, 32'h7777);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_mem();
    t_sum();
    t_countdown();
    t_flag_hold();
    t_wrap();
    t_illegal();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule